// File: doc/BRIEF.md
# Panel Vertical Compensation Line Sequencer

This block decides, for every line of a fixed-height flat panel, which source scanline the pixel fetch should read, or whether the line should be blank. It is used when the source mode has fewer lines than the panel. For example, a 350-line image on a 480-line panel leaves 130 panel lines with no source data. The block can fill or spread that gap in three ways. Centering splits the leftover lines into a top border and a bottom border. Stretching shows every Nth source line twice, and double scan is the case N = 1. Blank-row insertion adds a programmable number of blank lines after each text character row, which leaves the glyphs unchanged. Centering can be combined with either of the other two methods.

A `frame_start` pulse captures the configuration and restarts the sequence. The block first runs a short measuring pass over the source. It walks the same stepping logic once to find how many panel lines the compensated image needs, stopping early once that count reaches the panel height. From that count it sets the top border. It then presents one descriptor per panel line on a valid/ready stream, and the display timing generator pulls one descriptor per line by asserting `out_ready`. Back-pressure rules:
- Once `out_valid` rises, the descriptor stays unchanged until it is accepted.
- `out_valid` never falls without a handshake, except when a new `frame_start` arrives.
- A descriptor that is presented in the same cycle as `frame_start` is discarded.

Top module: `vcomp_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first `frame_start`, `out_valid` is 0.
- R2: With every compensation method off, panel line p carries source line p while p is below the source line count. The remaining panel lines are blank. A line that is not blank always names a source line below the captured source count.
- R3: With centering on and a compensated image height C below the panel height P, the first floor((P-C)/2) panel lines are blank, the image follows, and the remaining lines are blank. When C is P or more, there is no top border.
- R4: With stretching on and `cfg_rep_nm1` = N-1, a source line s is emitted twice in a row exactly when s mod N = N-1. The image height is S + floor(S/N). N = 1 is double scan.
- R5: With gap insertion on, text mode set, stretching off and `cfg_gap_lines` = B > 0, B blank lines follow the last line of every character row of height `cfg_row_hm1`+1. This includes the final row when it is complete. With text mode clear, or with B = 0, the gap setting has no effect.
- R6: If stretching and gap insertion are both enabled, only stretching is applied.
- R7: Each frame yields exactly P accepted descriptors, with rows 0 to P-1. Source lines beyond the panel are dropped. After the last descriptor, `out_valid` stays 0 until the next `frame_start`.
- R8: While `out_valid` is 1 and `out_ready` is 0, all descriptor fields hold their values and `out_valid` stays 1.
- R9: The configuration inputs are captured in the `frame_start` cycle. Changing them later in the frame has no effect on that frame.
- R10: `out_row` increments by one per accepted descriptor. A blank descriptor carries `out_line` = 0.
- R11: A `frame_start` arriving mid-frame drops `out_valid` in the next cycle. The new frame then starts again from panel line 0 with the newly captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that captures the configuration and restarts the sequence |
| cfg_src_lines | input | LINE_W | Source line count S |
| cfg_panel_lines | input | LINE_W | Panel line count P |
| cfg_center_en | input | 1 | Enable top/bottom border centering |
| cfg_stretch_en | input | 1 | Enable Nth-line replication |
| cfg_rep_nm1 | input | REP_W | Replication period N minus one |
| cfg_text_mode | input | 1 | Source is a text mode |
| cfg_gap_en | input | 1 | Enable blank-row insertion |
| cfg_gap_lines | input | GAP_W | Blank lines inserted after each character row |
| cfg_row_hm1 | input | ROWH_W | Character row height minus one (1 to 32 lines) |
| out_valid | output | 1 | Descriptor available |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_row | output | LINE_W | Panel line index |
| out_line | output | LINE_W | Source line to fetch, 0 when blank |
| out_blank | output | 1 | Drive border/background on this panel line |

## Verification
The bench sweeps small source and panel sizes with each compensation method off and on, and compares every descriptor with a model that works by division rather than by counting.
- Plain runs and runs with truncation separate correct bottom blanking from dropped source lines.
- Sweeps over the replication period, row height and gap count, each with and without centering, show whether repeats and gaps land on the right lines and whether the border is sized from the compensated height rather than the raw height.
- Frames with gap insertion in graphics mode, or with both methods requested, show that the mode qualifiers and the precedence are honoured.
- Stalling ready patterns, configuration changes after capture, and frames aborted by an early restart show that the sequence depends only on handshakes and on the captured state.

// File: rtl/vcomp_pkg.sv
package vcomp_pkg;

  // walker phase: emitting a source line, its repeat, or inserted gap lines
  typedef enum logic [1:0] {
    PH_SRC = 2'd0,
    PH_REP = 2'd1,
    PH_GAP = 2'd2
  } phase_t;

  // control sequence for one frame
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MEASURE = 2'd1,
    ST_CENTER  = 2'd2,
    ST_EMIT    = 2'd3
  } ctl_state_t;

endpackage

// File: rtl/vcomp_walker.sv
// Steps through the compensated source sequence, one panel line per advance.
module vcomp_walker
  import vcomp_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int REP_W  = 4,
  parameter int GAP_W  = 4,
  parameter int ROWH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              adv,
  input  logic              stretch_on,
  input  logic [REP_W-1:0]  rep_nm1,
  input  logic              gap_on,
  input  logic [GAP_W-1:0]  gap_lines,
  input  logic [ROWH_W-1:0] row_hm1,
  input  logic [LINE_W-1:0] src_lines,
  output logic [LINE_W-1:0] cur_line,
  output logic              cur_gap,
  output logic              done
);

  phase_t              phase_q;
  logic [LINE_W-1:0]   line_q;
  logic [REP_W-1:0]    grp_q;
  logic [ROWH_W-1:0]   rowpos_q;
  logic [GAP_W-1:0]    gapleft_q;

  logic grp_wrap, row_wrap, rep_hit, gap_hit;

  always_comb begin
    done     = (phase_q == PH_SRC) && (line_q >= src_lines);
    cur_gap  = (phase_q == PH_GAP);
    cur_line = line_q;
    grp_wrap = (grp_q == rep_nm1);
    row_wrap = (rowpos_q == row_hm1);
    rep_hit  = stretch_on && grp_wrap;
    gap_hit  = gap_on && row_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_SRC;
      line_q    <= '0;
      grp_q     <= '0;
      rowpos_q  <= '0;
      gapleft_q <= '0;
    end else if (restart) begin
      phase_q   <= PH_SRC;
      line_q    <= '0;
      grp_q     <= '0;
      rowpos_q  <= '0;
      gapleft_q <= '0;
    end else if (adv && !done) begin
      unique case (phase_q)
        PH_SRC: begin
          grp_q    <= grp_wrap ? '0 : grp_q + 1'b1;
          rowpos_q <= row_wrap ? '0 : rowpos_q + 1'b1;
          if (rep_hit) begin
            phase_q <= PH_REP;
          end else if (gap_hit) begin
            phase_q   <= PH_GAP;
            gapleft_q <= gap_lines;
          end else begin
            line_q <= line_q + 1'b1;
          end
        end
        PH_REP: begin
          phase_q <= PH_SRC;
          line_q  <= line_q + 1'b1;
        end
        default: begin
          gapleft_q <= gapleft_q - 1'b1;
          if (gapleft_q == GAP_W'(1)) begin
            phase_q <= PH_SRC;
            line_q  <= line_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vcomp_center.sv
// Top border size from the measured image height.
module vcomp_center #(
  parameter int LINE_W = 10
) (
  input  logic              center_en,
  input  logic [LINE_W-1:0] content,
  input  logic [LINE_W-1:0] panel,
  output logic [LINE_W-1:0] top
);

  logic [LINE_W-1:0] spare;

  always_comb begin
    spare = panel - content;
    if (center_en && (content < panel)) top = spare >> 1;
    else                                top = '0;
  end

endmodule

// File: rtl/vcomp_ctrl.sv
// Frame control: configuration capture, measure pass, border, output stream.
module vcomp_ctrl
  import vcomp_pkg::*;
#(
  parameter int LINE_W = 10,
  parameter int REP_W  = 4,
  parameter int GAP_W  = 4,
  parameter int ROWH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [LINE_W-1:0] cfg_src_lines,
  input  logic [LINE_W-1:0] cfg_panel_lines,
  input  logic              cfg_center_en,
  input  logic              cfg_stretch_en,
  input  logic [REP_W-1:0]  cfg_rep_nm1,
  input  logic              cfg_text_mode,
  input  logic              cfg_gap_en,
  input  logic [GAP_W-1:0]  cfg_gap_lines,
  input  logic [ROWH_W-1:0] cfg_row_hm1,
  // walker side
  input  logic [LINE_W-1:0] w_line,
  input  logic              w_gap,
  input  logic              w_done,
  output logic              w_restart,
  output logic              w_adv,
  output logic              stretch_q,
  output logic [REP_W-1:0]  rep_q,
  output logic              gap_on_q,
  output logic [GAP_W-1:0]  gap_lines_q,
  output logic [ROWH_W-1:0] rowh_q,
  output logic [LINE_W-1:0] src_q,
  output logic [LINE_W-1:0] panel_q,
  // border calculator side
  output logic              center_q,
  output logic [LINE_W-1:0] count_q,
  input  logic [LINE_W-1:0] top_in,
  // stream
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_row,
  output logic [LINE_W-1:0] out_line,
  output logic              out_blank
);

  ctl_state_t        state_q;
  logic [LINE_W-1:0] top_q;
  logic [LINE_W-1:0] row_q;
  logic              in_image, hs, meas_step, meas_end;

  always_comb begin
    in_image  = (row_q >= top_q) && !w_done;
    out_valid = (state_q == ST_EMIT);
    hs        = out_valid && out_ready;
    out_row   = row_q;
    out_blank = !in_image || w_gap;
    out_line  = out_blank ? '0 : w_line;
    meas_end  = w_done || (count_q == panel_q);
    meas_step = (state_q == ST_MEASURE) && !meas_end;
    w_restart = frame_start || (state_q == ST_CENTER);
    w_adv     = !frame_start && (meas_step || (hs && in_image));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      center_q    <= 1'b0;
      stretch_q   <= 1'b0;
      rep_q       <= '0;
      gap_on_q    <= 1'b0;
      gap_lines_q <= '0;
      rowh_q      <= '0;
      src_q       <= '0;
      panel_q     <= '0;
      count_q     <= '0;
      top_q       <= '0;
      row_q       <= '0;
    end else if (frame_start) begin
      state_q     <= ST_MEASURE;
      center_q    <= cfg_center_en;
      stretch_q   <= cfg_stretch_en;
      rep_q       <= cfg_rep_nm1;
      gap_on_q    <= cfg_gap_en && cfg_text_mode && !cfg_stretch_en
                     && (cfg_gap_lines != '0);
      gap_lines_q <= cfg_gap_lines;
      rowh_q      <= cfg_row_hm1;
      src_q       <= cfg_src_lines;
      panel_q     <= cfg_panel_lines;
      count_q     <= '0;
      row_q       <= '0;
    end else begin
      unique case (state_q)
        ST_MEASURE: begin
          if (meas_end) state_q <= ST_CENTER;
          else          count_q <= count_q + 1'b1;
        end
        ST_CENTER: begin
          top_q   <= top_in;
          row_q   <= '0;
          state_q <= (panel_q == '0) ? ST_IDLE : ST_EMIT;
        end
        ST_EMIT: begin
          if (hs) begin
            row_q <= row_q + 1'b1;
            if (row_q == panel_q - 1'b1) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vcomp_seq.sv
// Flat panel vertical compensation line sequencer (top).
module vcomp_seq #(
  parameter int LINE_W = 10,
  parameter int REP_W  = 4,
  parameter int GAP_W  = 4,
  parameter int ROWH_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [LINE_W-1:0] cfg_src_lines,
  input  logic [LINE_W-1:0] cfg_panel_lines,
  input  logic              cfg_center_en,
  input  logic              cfg_stretch_en,
  input  logic [REP_W-1:0]  cfg_rep_nm1,
  input  logic              cfg_text_mode,
  input  logic              cfg_gap_en,
  input  logic [GAP_W-1:0]  cfg_gap_lines,
  input  logic [ROWH_W-1:0] cfg_row_hm1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_row,
  output logic [LINE_W-1:0] out_line,
  output logic              out_blank
);

  logic [LINE_W-1:0] w_line, cfg_src_q, cfg_panel_q, count_q, top_w;
  logic              w_gap, w_done, w_restart, w_adv;
  logic              stretch_q, gap_on_q, center_q;
  logic [REP_W-1:0]  rep_q;
  logic [GAP_W-1:0]  gap_lines_q;
  logic [ROWH_W-1:0] rowh_q;

  vcomp_ctrl #(
    .LINE_W(LINE_W), .REP_W(REP_W), .GAP_W(GAP_W), .ROWH_W(ROWH_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_src_lines(cfg_src_lines), .cfg_panel_lines(cfg_panel_lines),
    .cfg_center_en(cfg_center_en), .cfg_stretch_en(cfg_stretch_en),
    .cfg_rep_nm1(cfg_rep_nm1), .cfg_text_mode(cfg_text_mode),
    .cfg_gap_en(cfg_gap_en), .cfg_gap_lines(cfg_gap_lines),
    .cfg_row_hm1(cfg_row_hm1),
    .w_line(w_line), .w_gap(w_gap), .w_done(w_done),
    .w_restart(w_restart), .w_adv(w_adv),
    .stretch_q(stretch_q), .rep_q(rep_q), .gap_on_q(gap_on_q),
    .gap_lines_q(gap_lines_q), .rowh_q(rowh_q),
    .src_q(cfg_src_q), .panel_q(cfg_panel_q),
    .center_q(center_q), .count_q(count_q), .top_in(top_w),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_line(out_line), .out_blank(out_blank)
  );

  vcomp_walker #(
    .LINE_W(LINE_W), .REP_W(REP_W), .GAP_W(GAP_W), .ROWH_W(ROWH_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .restart(w_restart), .adv(w_adv),
    .stretch_on(stretch_q), .rep_nm1(rep_q), .gap_on(gap_on_q),
    .gap_lines(gap_lines_q), .row_hm1(rowh_q), .src_lines(cfg_src_q),
    .cur_line(w_line), .cur_gap(w_gap), .done(w_done)
  );

  vcomp_center #(.LINE_W(LINE_W)) u_center (
    .center_en(center_q), .content(count_q), .panel(cfg_panel_q),
    .top(top_w)
  );

endmodule

// File: rtl/vcomp_seq_chk.sv
module vcomp_seq_chk #(
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LINE_W-1:0] out_row,
  input logic [LINE_W-1:0] out_line,
  input logic              out_blank,
  input logic [LINE_W-1:0] src_q,
  input logic [LINE_W-1:0] panel_q
);

  // R1: no descriptor while reset is held
  always_comb begin
    if (!rst_n) p_idle_in_reset_r1: assert (!out_valid);
  end

  // R8: a stalled descriptor holds
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=>
      (out_valid && $stable(out_row) && $stable(out_line) && $stable(out_blank)));

  // R10: blank lines carry line zero
  p_blank_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_blank) |-> (out_line == '0));

  // R10: row advances by one per handshake
  p_row_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !frame_start) |=>
      (frame_start || !out_valid || (out_row == LINE_W'($past(out_row) + 1'b1))));

  // R7: row stays within the panel
  p_row_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row < panel_q));

  // R2: a visible line is a real source line
  p_line_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_blank) |-> (out_line < src_q));

  // R11: restart withdraws the stream
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !out_valid);

endmodule

bind vcomp_seq vcomp_seq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
  .out_line(out_line), .out_blank(out_blank),
  .src_q(cfg_src_q), .panel_q(cfg_panel_q)
);

// File: tb/vcomp_seq_bench.sv
module vcomp_seq_bench;

  localparam int LINE_W = 10;
  localparam int REP_W  = 4;
  localparam int GAP_W  = 4;
  localparam int ROWH_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0;
  logic [LINE_W-1:0] cfg_src_lines = '0;
  logic [LINE_W-1:0] cfg_panel_lines = '0;
  logic              cfg_center_en = 1'b0;
  logic              cfg_stretch_en = 1'b0;
  logic [REP_W-1:0]  cfg_rep_nm1 = '0;
  logic              cfg_text_mode = 1'b0;
  logic              cfg_gap_en = 1'b0;
  logic [GAP_W-1:0]  cfg_gap_lines = '0;
  logic [ROWH_W-1:0] cfg_row_hm1 = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [LINE_W-1:0] out_row;
  logic [LINE_W-1:0] out_line;
  logic              out_blank;

  always #4 clk = ~clk;  // 125 MHz

  vcomp_seq #(.LINE_W(LINE_W), .REP_W(REP_W), .GAP_W(GAP_W), .ROWH_W(ROWH_W))
  u_vcomp_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_src_lines(cfg_src_lines), .cfg_panel_lines(cfg_panel_lines),
    .cfg_center_en(cfg_center_en), .cfg_stretch_en(cfg_stretch_en),
    .cfg_rep_nm1(cfg_rep_nm1), .cfg_text_mode(cfg_text_mode),
    .cfg_gap_en(cfg_gap_en), .cfg_gap_lines(cfg_gap_lines),
    .cfg_row_hm1(cfg_row_hm1), .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_line(out_line), .out_blank(out_blank)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // captured frame configuration for the model
  int e_src, e_panel, e_ce, e_st, e_rep, e_txt, e_ge, e_gl, e_hm1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // arithmetic model of panel line p
  function automatic void model(input int p, output bit blk, output int ln);
    int n, h, b, content, top, k, g, r;
    bit gon;
    n   = e_rep + 1;
    h   = e_hm1 + 1;
    b   = e_gl;
    gon = e_ge && e_txt && !e_st && (b > 0);
    if (e_st)     content = e_src + e_src / n;
    else if (gon) content = e_src + (e_src / h) * b;
    else          content = e_src;
    top = (e_ce && content < e_panel) ? (e_panel - content) / 2 : 0;
    blk = 1'b1;
    ln  = 0;
    if (p < top) return;
    k = p - top;
    if (k >= content) return;
    if (e_st) begin
      g = k / (n + 1);
      r = k % (n + 1);
      ln = g * n + ((r == n) ? n - 1 : r);
      blk = 1'b0;
    end else if (gon) begin
      g = k / (h + b);
      r = k % (h + b);
      if (r < h) begin
        ln = g * h + r;
        blk = 1'b0;
      end
    end else begin
      ln = k;
      blk = 1'b0;
    end
  endfunction

  function automatic bit ready_pat(input int pm);
    case (pm)
      0: return 1'b1;
      1: return (cyc % 4) != 1;
      default: return (cyc % 3) == 0;
    endcase
  endfunction

  task automatic run_frame(input int src, input int panel, input int ce,
                           input int st, input int rep, input int txt,
                           input int ge, input int gl, input int hm1,
                           input int pm, input int abort_n, input string tag);
    int p, guard, lim, eln;
    bit eblk, stalled, rdy;
    @(negedge clk);
    out_ready       = 1'b0;
    cfg_src_lines   = LINE_W'(src);
    cfg_panel_lines = LINE_W'(panel);
    cfg_center_en   = ce[0];
    cfg_stretch_en  = st[0];
    cfg_rep_nm1     = REP_W'(rep);
    cfg_text_mode   = txt[0];
    cfg_gap_en      = ge[0];
    cfg_gap_lines   = GAP_W'(gl);
    cfg_row_hm1     = ROWH_W'(hm1);
    frame_start     = 1'b1;
    e_src = src; e_panel = panel; e_ce = ce; e_st = st; e_rep = rep;
    e_txt = txt; e_ge = ge; e_gl = gl; e_hm1 = hm1;
    @(negedge clk);
    frame_start = 1'b0;
    // R9: scramble the inputs after capture
    cfg_src_lines   = ~cfg_src_lines;
    cfg_panel_lines = LINE_W'(panel + 7);
    cfg_center_en   = ~cfg_center_en;
    cfg_stretch_en  = ~cfg_stretch_en;
    cfg_rep_nm1     = ~cfg_rep_nm1;
    cfg_text_mode   = ~cfg_text_mode;
    cfg_gap_en      = ~cfg_gap_en;
    cfg_gap_lines   = ~cfg_gap_lines;
    cfg_row_hm1     = ~cfg_row_hm1;
    lim = (abort_n > 0 && abort_n < panel) ? abort_n : panel;
    p = 0;
    guard = 0;
    stalled = 1'b0;
    while (p < lim) begin
      if (guard > 4000) begin
        chk(1'b0, {tag, " stream stalled"}, p, lim);
        break;
      end
      if (guard > 0) @(negedge clk);
      guard++;
      rdy = 1'b0;
      if (out_valid) begin
        model(p, eblk, eln);
        chk(out_row == LINE_W'(p), stalled ? "R8 row" : "R10 row", int'(out_row), p);
        chk(out_blank == eblk, stalled ? "R8 blank" : {tag, " blank"},
            int'(out_blank), int'(eblk));
        chk(out_line == LINE_W'(eln), stalled ? "R8 line" : {tag, " line"},
            int'(out_line), eln);
        rdy = ready_pat(pm);
        stalled = !rdy;
        if (rdy) p++;
      end
      out_ready = rdy;
    end
    @(negedge clk);
    out_ready = 1'b0;
    if (abort_n == 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(!out_valid, "R7 idle after frame", int'(out_valid), 0);
        @(negedge clk);
      end
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !finished) begin
        finished = 1'b1;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R1 in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid, "R1 before frame", int'(out_valid), 0);
    end

    // R2: plain mapping, short and empty sources
    run_frame(0, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
    run_frame(5, 24, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R2");
    run_frame(24, 24, 0, 0, 0, 0, 0, 0, 0, 2, 0, "R2");
    // R7: truncation
    run_frame(30, 24, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R7");
    run_frame(20, 24, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R7");

    // R3: centering sweep
    for (int s = 1; s <= 25; s += 3)
      run_frame(s, 24, 1, 0, 0, 0, 0, 0, 0, s % 3, 0, "R3");

    // R4: replication period sweep, with and without centering
    for (int rep = 0; rep < 4; rep++)
      for (int s = 6; s <= 12; s += 3)
        for (int ce = 0; ce < 2; ce++)
          run_frame(s, 28, ce, 1, rep, ce, 0, 0, 0, (rep + s) % 3, 0, "R4");

    // R5: row height and gap sweep in text mode
    for (int hm1 = 0; hm1 < 4; hm1++)
      for (int gl = 0; gl < 4; gl++)
        for (int ce = 0; ce < 2; ce++)
          run_frame(9, 30, ce, 0, 0, 1, 1, gl, hm1, (hm1 + gl) % 3, 0, "R5");
    // R5: graphics mode ignores the gap setting
    run_frame(9, 30, 1, 0, 0, 0, 1, 2, 1, 1, 0, "R5 graphics");
    run_frame(9, 30, 0, 0, 0, 0, 1, 3, 2, 0, 0, "R5 graphics");

    // R6: both requested, stretching wins
    run_frame(10, 30, 1, 1, 1, 1, 1, 2, 1, 1, 0, "R6");
    run_frame(8, 30, 0, 1, 0, 1, 1, 3, 0, 2, 0, "R6");

    // R9: inputs scrambled after capture on a mixed configuration
    run_frame(14, 26, 1, 0, 0, 1, 1, 1, 2, 1, 0, "R9");

    // R11: abort mid-frame, restart with another configuration
    run_frame(20, 30, 0, 1, 2, 0, 0, 0, 0, 0, 5, "R11 first");
    run_frame(7, 20, 1, 0, 0, 1, 1, 2, 1, 1, 0, "R11");
    run_frame(12, 24, 1, 1, 0, 0, 0, 0, 0, 2, 9, "R11 first");
    run_frame(12, 24, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule